// File: doc/BRIEF.md
# Paired Doubleword Load-with-Update Unit

This unit carries out one load-pair-with-update instruction. A start strobe hands it a 32-bit instruction word. The unit checks that the word has the expected encoding and builds an effective address. The address is a sign-extended displacement scaled by four, added to a base general-purpose register, or used on its own when the base field names register zero.

The unit then makes two 64-bit reads, one after the other, at the effective address and at the effective address plus 8. It writes the two results into consecutive floating-point registers; the register after 31 is 0. When the base field is nonzero, it writes the effective address back into that base register. A one-cycle done pulse marks the end.

An instruction with the wrong encoding produces a one-cycle illegal pulse and changes nothing. The register files and the memory sit outside the block. The GPR read port is combinational, and each memory read is held until a one-cycle valid response arrives.

Top module: `pair_load_top`

## Requirements
- R1: An instruction is legal only when instr[31:26] equals 57 and instr[1:0] equals 0. Any other word gives exactly one illegal pulse and no memory request, no register write and no done.
- R2: The target FPR index is instr[25:21], the base GPR index is instr[20:16] (driven on gprRdIdx) and the 14-bit displacement is instr[15:2].
- R3: The byte offset is the displacement sign-extended to 30 bits with two zero bits appended below it, so negative displacements reach lower addresses.
- R4: When the base index is 0, the effective address is the offset alone, whatever GPR 0 holds.
- R5: When the base index is nonzero, the effective address is the offset plus the base GPR contents, modulo 2^32.
- R6: The first read goes out at the effective address, and its data is written to FPR instr[25:21].
- R7: The second read goes out at the effective address plus 8 (modulo 2^32), and only after the first read's valid. Its data goes to the next FPR index, and FPR 31 is followed by FPR 0.
- R8: memReq stays high on a read until memRdValid is seen, and each valid causes exactly one FPR write in the same cycle.
- R9: When the base index is nonzero, the effective address is written to that GPR after both FPR writes. When it is zero, no GPR is written.
- R10: done is a single-cycle pulse, asserted in the cycle after the write-back step.
- R11: A start while an instruction is in progress is ignored.
- R12: After reset the unit is idle, with memReq, fprWrEn, gprWrEn, done and illegal all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the instruction on instr |
| instr | input | 32 | Instruction word |
| gprRdIdx | output | 5 | Base GPR read index |
| gprRdData | input | 32 | Base GPR contents (combinational read) |
| gprWrEn | output | 1 | Base GPR write strobe |
| gprWrIdx | output | 5 | Base GPR write index |
| gprWrData | output | 32 | Updated base value |
| fprWrEn | output | 1 | FPR write strobe |
| fprWrIdx | output | 5 | FPR write index |
| fprWrData | output | 64 | FPR write data |
| memReq | output | 1 | Read request, held until valid |
| memAddr | output | 32 | Read byte address |
| memRdValid | input | 1 | Read data valid (one cycle) |
| memRdData | input | 64 | Read data |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Illegal-encoding pulse |

## Verification
The main flow is driven with several kinds of instruction. A nonzero base with a positive displacement separates the base-add path and the write-back from the zero-base path. A negative displacement with base zero exposes the sign extension and the way EA+8 wraps past the top of the address space. A target of 31 shows the register wrap to 0. A large base value, the largest positive displacement and a negative displacement against a small base test the 32-bit modulo arithmetic. Memory latencies from zero to several cycles check that each request is held and that the second read waits for the first. Words with a wrong opcode or wrong low bits, and a start strobe raised in the middle of an instruction, must leave the scoreboard's expected event stream exactly as it was.

// File: rtl/pair_load_pkg.sv
package pair_load_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_RD0,
    S_RD1,
    S_UPD,
    S_FIN,
    S_BAD
  } stateT;

  typedef struct packed {
    logic latchInstr;
    logic latchEa;
    logic memReq;
    logic selSecond;
    logic fprWr;
    logic gprWr;
    logic done;
    logic illegal;
  } strobeT;

endpackage

// File: rtl/pair_load_dp.sv
module pair_load_dp
  import pair_load_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5,
  parameter int DISP_W = 14,
  parameter int OPCODE = 57,
  parameter int STRIDE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [31:0]       instr,
  output logic              legal,
  output logic              baseZero,
  output logic [IDX_W-1:0]  gprRdIdx,
  input  logic [ADDR_W-1:0] gprRdData,
  output logic [IDX_W-1:0]  gprWrIdx,
  output logic [ADDR_W-1:0] gprWrData,
  output logic [IDX_W-1:0]  fprWrIdx,
  output logic [DATA_W-1:0] fprWrData,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData
);

  localparam int INSTR_W = 32;
  localparam int OPC_W   = INSTR_W - 2 * IDX_W - DISP_W - 2;
  localparam int OPC_LO  = INSTR_W - OPC_W;
  localparam int FRT_LO  = OPC_LO - IDX_W;
  localparam int RA_LO   = FRT_LO - IDX_W;
  localparam int DISP_LO = 2;
  localparam int EXT_W   = ADDR_W - DISP_W - 2;

  logic [INSTR_W-1:0] instReg;
  logic [ADDR_W-1:0]  eaReg;
  logic [OPC_W-1:0]   opcField;
  logic [IDX_W-1:0]   frtField;
  logic [IDX_W-1:0]   raField;
  logic [DISP_W-1:0]  dispField;
  logic [1:0]         tailField;
  logic [ADDR_W-1:0]  offset;
  logic [ADDR_W-1:0]  baseVal;
  logic [ADDR_W-1:0]  eaNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instReg <= '0;
      eaReg   <= '0;
    end else begin
      if (stb.latchInstr) instReg <= instr;
      if (stb.latchEa)    eaReg   <= eaNext;
    end
  end

  always_comb begin
    opcField  = instReg[INSTR_W-1 -: OPC_W];
    frtField  = instReg[FRT_LO +: IDX_W];
    raField   = instReg[RA_LO +: IDX_W];
    dispField = instReg[DISP_LO +: DISP_W];
    tailField = instReg[1:0];
    legal     = (opcField == OPC_W'(OPCODE)) && (tailField == 2'b00);
    baseZero  = (raField == '0);
    offset    = {{EXT_W{dispField[DISP_W-1]}}, dispField, 2'b00};
    baseVal   = baseZero ? '0 : gprRdData;
    eaNext    = offset + baseVal;
  end

  assign gprRdIdx  = raField;
  assign gprWrIdx  = raField;
  assign gprWrData = eaReg;
  assign memAddr   = stb.selSecond ? eaReg + ADDR_W'(STRIDE) : eaReg;
  assign fprWrIdx  = stb.selSecond ? frtField + IDX_W'(1) : frtField;
  assign fprWrData = memRdData;

endmodule

// File: rtl/pair_load_ctrl.sv
module pair_load_ctrl
  import pair_load_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   legal,
  input  logic   baseZero,
  input  logic   memRdValid,
  output strobeT stb
);

  stateT state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (start) stateNext = S_CHECK;
      S_CHECK: stateNext = legal ? S_RD0 : S_BAD;
      S_RD0:   if (memRdValid) stateNext = S_RD1;
      S_RD1:   if (memRdValid) stateNext = S_UPD;
      S_UPD:   stateNext = S_FIN;
      S_FIN:   stateNext = S_IDLE;
      S_BAD:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    stb            = '0;
    stb.latchInstr = (state == S_IDLE) && start;
    stb.latchEa    = (state == S_CHECK) && legal;
    stb.memReq     = (state == S_RD0) || (state == S_RD1);
    stb.selSecond  = (state == S_RD1);
    stb.fprWr      = stb.memReq && memRdValid;
    stb.gprWr      = (state == S_UPD) && !baseZero;
    stb.done       = (state == S_FIN);
    stb.illegal    = (state == S_BAD);
  end

endmodule

// File: rtl/pair_load_top.sv
module pair_load_top
  import pair_load_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5,
  parameter int DISP_W = 14,
  parameter int OPCODE = 57,
  parameter int STRIDE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [31:0]       instr,
  output logic [IDX_W-1:0]  gprRdIdx,
  input  logic [ADDR_W-1:0] gprRdData,
  output logic              gprWrEn,
  output logic [IDX_W-1:0]  gprWrIdx,
  output logic [ADDR_W-1:0] gprWrData,
  output logic              fprWrEn,
  output logic [IDX_W-1:0]  fprWrIdx,
  output logic [DATA_W-1:0] fprWrData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic              done,
  output logic              illegal
);

  strobeT stb;
  logic   legal;
  logic   baseZero;

  pair_load_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .legal      (legal),
    .baseZero   (baseZero),
    .memRdValid (memRdValid),
    .stb        (stb)
  );

  pair_load_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .DISP_W (DISP_W),
    .OPCODE (OPCODE),
    .STRIDE (STRIDE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .instr     (instr),
    .legal     (legal),
    .baseZero  (baseZero),
    .gprRdIdx  (gprRdIdx),
    .gprRdData (gprRdData),
    .gprWrIdx  (gprWrIdx),
    .gprWrData (gprWrData),
    .fprWrIdx  (fprWrIdx),
    .fprWrData (fprWrData),
    .memAddr   (memAddr),
    .memRdData (memRdData)
  );

  assign gprWrEn = stb.gprWr;
  assign fprWrEn = stb.fprWr;
  assign memReq  = stb.memReq;
  assign done    = stb.done;
  assign illegal = stb.illegal;

endmodule

// File: rtl/pair_load_chk.sv
module pair_load_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             memReq,
  input logic             memRdValid,
  input logic             fprWrEn,
  input logic             gprWrEn,
  input logic [IDX_W-1:0] gprWrIdx,
  input logic             done,
  input logic             illegal
);

  // R1: an illegal pulse comes with no other activity and lasts one cycle
  a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !memReq && !fprWrEn && !gprWrEn && !done);
  a_r1_illegal_pulse: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> !illegal);

  // R8: a request stays up until it is answered
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memRdValid |=> memReq);
  a_r8_fpr_on_valid: assert property (@(posedge clk) disable iff (!rstN)
    fprWrEn |-> memReq && memRdValid);

  // R9: write-back targets a nonzero base and is followed by done
  a_r9_base_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    gprWrEn |-> gprWrIdx != '0);
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    gprWrEn |-> !memReq && !fprWrEn);

  // R10: done follows the write-back step and is a single pulse
  a_r10_after_wb: assert property (@(posedge clk) disable iff (!rstN)
    gprWrEn |=> done);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind pair_load_top pair_load_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .memReq     (memReq),
  .memRdValid (memRdValid),
  .fprWrEn    (fprWrEn),
  .gprWrEn    (gprWrEn),
  .gprWrIdx   (gprWrIdx),
  .done       (done),
  .illegal    (illegal)
);

// File: tb/sim_pair_load_top.sv
`timescale 1ns/1ps
module sim_pair_load_top;

  typedef enum int {K_MEM, K_FPR, K_GPR, K_DONE, K_ILL} kindT;
  typedef struct {
    kindT        kind;
    int          idx;
    logic [63:0] data;
    string       req;
  } itemT;

  logic        clk = 0;
  logic        rstN = 0;
  logic        start = 0;
  logic [31:0] instr = '0;
  logic [4:0]  gprRdIdx;
  logic [31:0] gprRdData;
  logic        gprWrEn;
  logic [4:0]  gprWrIdx;
  logic [31:0] gprWrData;
  logic        fprWrEn;
  logic [4:0]  fprWrIdx;
  logic [63:0] fprWrData;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRdValid = 0;
  logic [63:0] memRdData = '0;
  logic        done;
  logic        illegal;

  logic [31:0] gprs [32];
  itemT        sbQ [$];
  int          compared = 0;
  int          mismatched = 0;
  int          lat = 0;
  int          waitCnt = 0;
  int          cycles = 0;

  always #10 clk = ~clk;

  assign gprRdData = gprs[gprRdIdx];

  pair_load_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr),
    .gprRdIdx(gprRdIdx), .gprRdData(gprRdData),
    .gprWrEn(gprWrEn), .gprWrIdx(gprWrIdx), .gprWrData(gprWrData),
    .fprWrEn(fprWrEn), .fprWrIdx(fprWrIdx), .fprWrData(fprWrData),
    .memReq(memReq), .memAddr(memAddr),
    .memRdValid(memRdValid), .memRdData(memRdData),
    .done(done), .illegal(illegal)
  );

  function automatic logic [63:0] memVal(logic [31:0] a);
    return {a ^ 32'hA5A5_0F0F, a};
  endfunction

  function automatic logic [31:0] mk(int opc, int frt, int ra, int d, int lo);
    return {6'(opc), 5'(frt), 5'(ra), 14'(d), 2'(lo)};
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // register file environment
  always @(posedge clk) if (gprWrEn) gprs[gprWrIdx] <= gprWrData;

  // memory responder, drives after the edge
  always begin
    @(posedge clk);
    #2;
    if (memRdValid) memRdValid = 0;
    else if (memReq) begin
      if (waitCnt >= lat) begin
        memRdValid = 1;
        memRdData  = memVal(memAddr);
        waitCnt    = 0;
      end else waitCnt++;
    end
  end

  task automatic expectOne(kindT k, int idx, logic [63:0] d, string r, logic [63:0] act, int actIdx);
    itemT e;
    compared++;
    if (sbQ.size() == 0) begin
      mismatched++;
      $display("FAIL %s: unexpected event kind=%0d idx=%0d data=%h, expected none", r, k, actIdx, act);
      return;
    end
    e = sbQ.pop_front();
    if (e.kind != k || e.idx != actIdx || e.data != act) begin
      mismatched++;
      $display("FAIL %s: actual kind=%0d idx=%0d data=%h expected kind=%0d idx=%0d data=%h",
               e.req, k, actIdx, act, e.kind, e.idx, e.data);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (memReq && memRdValid) expectOne(K_MEM, 0, {32'h0, memAddr}, "R8", {32'h0, memAddr}, 0);
      if (fprWrEn) expectOne(K_FPR, 0, fprWrData, "R7", fprWrData, int'(fprWrIdx));
      if (gprWrEn) expectOne(K_GPR, 0, {32'h0, gprWrData}, "R9", {32'h0, gprWrData}, int'(gprWrIdx));
      if (done)    expectOne(K_DONE, 0, '0, "R10", '0, 0);
      if (illegal) expectOne(K_ILL, 0, '0, "R1", '0, 0);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual cycles=%0d expected under 100000", cycles);
      summary();
    end
  end

  function automatic void push(kindT k, int idx, logic [63:0] d, string r);
    itemT e;
    e.kind = k; e.idx = idx; e.data = d; e.req = r;
    sbQ.push_back(e);
  endfunction

  task automatic runOp(logic [31:0] ins, int latency, bit poke, string tag);
    logic [13:0] d;
    logic [31:0] off, ea, ea2;
    int frt, ra;
    lat = latency;
    frt = int'(ins[25:21]);
    ra  = int'(ins[20:16]);
    d   = ins[15:2];
    if (ins[31:26] == 6'd57 && ins[1:0] == 2'b00) begin
      off = {{16{d[13]}}, d, 2'b00};
      ea  = off + (ra == 0 ? 32'h0 : gprs[ra]);
      ea2 = ea + 32'd8;
      push(K_MEM, 0, {32'h0, ea}, {tag, " R6 addr"});
      push(K_FPR, frt, memVal(ea), {tag, " R6 first"});
      push(K_MEM, 0, {32'h0, ea2}, {tag, " R7 addr"});
      push(K_FPR, (frt + 1) % 32, memVal(ea2), {tag, " R7 second"});
      if (ra != 0) push(K_GPR, ra, {32'h0, ea}, {tag, " R9 update"});
      push(K_DONE, 0, '0, {tag, " R10 done"});
    end else begin
      push(K_ILL, 0, '0, {tag, " R1 illegal"});
    end
    @(negedge clk);
    start = 1; instr = ins;
    @(negedge clk);
    start = 0;
    if (poke) begin // R11: start during busy
      @(negedge clk);
      start = 1; instr = mk(57, 2, 4, 100, 0);
      @(negedge clk);
      start = 0;
    end
    wait (sbQ.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) gprs[i] = 32'h1000_0000 + 32'(i) * 32'h100;
    gprs[0] = 32'hDEAD_0000;
    gprs[3] = 32'h0000_1000;
    gprs[7] = 32'h0000_0020;
    gprs[12] = 32'hFFFF_FFF8;
    repeat (3) @(negedge clk);
    // R12: reset state
    compared++;
    if (memReq || fprWrEn || gprWrEn || done || illegal) begin
      mismatched++;
      $display("FAIL R12: actual outputs %b%b%b%b%b expected 00000",
               memReq, fprWrEn, gprWrEn, done, illegal);
    end
    rstN = 1;
    @(negedge clk);
    runOp(mk(57, 9, 3, 4, 0), 0, 0, "R2 R5 base3");
    runOp(mk(57, 5, 0, -1, 0), 2, 0, "R3 R4 neg zero-base");
    runOp(mk(57, 31, 3, 2, 0), 1, 0, "R7 wrap31");
    runOp(mk(57, 14, 7, -16, 0), 3, 0, "R3 R5 neg base");
    runOp(mk(57, 20, 12, 1, 0), 0, 0, "R5 modulo");
    runOp(mk(57, 0, 0, 14'h1FFF, 0), 1, 0, "R3 maxpos");
    runOp(mk(56, 9, 3, 4, 0), 0, 0, "R1 bad opcode");
    runOp(mk(57, 9, 3, 4, 2), 0, 0, "R1 bad tail");
    runOp(mk(57, 30, 3, 8, 0), 4, 1, "R11 busy start");
    runOp(mk(57, 1, 5, 3, 0), 0, 0, "R8 back-to-back");
    // R1 R9: nothing left pending and base unchanged by illegal words
    compared++;
    if (sbQ.size() != 0) begin
      mismatched++;
      $display("FAIL R1: actual pending=%0d expected 0", sbQ.size());
    end
    summary();
  end

endmodule